// File: doc/BRIEF.md
# Memory Protection Region Checker

The block decides, in the same cycle, whether a memory access may go ahead. A software-visible write port loads a table of eight protection regions. Each region has a base address, a power-of-two size, an enable bit, a 3-bit permission code and a set of memory attributes. Each access presents an address, a privilege flag and a kind (instruction fetch, data read or data write). The block returns the number of the winning region, that region's attributes and a fault flag. Where regions overlap, the highest-numbered region wins. An address that no region covers lands in a background region, which only privileged code may use. Fetches and data accesses are checked against the same table.

A small two-state machine records the first faulting access. It keeps the address, kind and privilege of that access until software clears it by writing the clear slot. The states are FS_EMPTY and FS_HELD. The transitions are:

- CAPTURE: FS_EMPTY to FS_HELD, on a fault.
- HOLD: stay in FS_HELD when no clear arrives.
- CLEAR: FS_HELD to FS_EMPTY, on a clear with no fault in the same cycle.
- RECAPTURE: stay in FS_HELD and load the new access, on a clear together with a fault.

Top module: `prot_region_chk`

## Requirements
- R1: The write port has a 5-bit slot number. For region n (0..7), slot 2n is the base word: data bits 31:5 give base bits 31:5. Slot 2n+1 is the control word: bit 0 enable, bits 5:1 size code, bits 10:8 permission code, bit 12 execute-never, bits 18:16 type extension, bit 19 shareable, bit 20 cacheable, bit 21 bufferable. Slot 16 bit 0 is the global enable, and any write to slot 17 clears the fault record. A write takes effect from the cycle after it is presented. Reset clears all of it.
- R2: With size code S, a region covers 2^(S+1) bytes and matches when the address bits above bit S equal the base bits. Base bits below the size are ignored. A size code below 4 never matches, and neither does a region with its enable bit clear.
- R3: When several enabled regions match, acc_region reports the highest-numbered one. Its attributes and permission code are then used.
- R4: With checking enabled and no region matched, acc_hit is 0 and acc_region is 0. All attribute outputs are 0. A privileged access is granted and an unprivileged access faults.
- R5: The permission codes are:
  - 0: no access.
  - 1: privileged read/write only.
  - 2: privileged read/write, unprivileged read.
  - 3: read/write for all.
  - 5: privileged read only.
  - 6: read only for all.
  - 4 and 7: deny everything.
- R6: A fetch (acc_kind 0) that hits a region with execute-never set faults, whatever its permission code.
- R7: Fetches and reads (acc_kind 1, and the unused code 3) need read permission from the one shared table. Writes (acc_kind 2) need write permission.
- R8: On a hit, the region's type extension, cacheable, bufferable and execute-never bits are passed through unchanged. The shareable output is the region's bit, forced to 1 when type extension, cacheable and bufferable are all 0 (strongly ordered).
- R9: With the global enable clear, every access is granted: no fault, acc_hit 0, acc_region 0 and all attributes 0.
- R10: The first fault seen in FS_EMPTY is recorded on the next clock (fs_valid, fs_addr, fs_kind, fs_priv). Later faults do not overwrite it. A clear empties the record, unless a fault arrives in the same cycle; that fault is then recorded.
- R11: acc_fault is 0 whenever acc_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration slot number |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | An access is being presented |
| acc_addr | input | 32 | Access byte address |
| acc_priv | input | 1 | Access is privileged |
| acc_kind | input | 2 | 0 fetch, 1 read, 2 write, 3 treated as read |
| acc_fault | output | 1 | Access denied |
| acc_hit | output | 1 | A programmed region matched |
| acc_region | output | 3 | Winning region number |
| attr_tex | output | 3 | Type extension of the winning region |
| attr_cach | output | 1 | Cacheable |
| attr_buff | output | 1 | Bufferable |
| attr_shr | output | 1 | Shareable (forced for strongly ordered) |
| attr_xn | output | 1 | Execute-never |
| fs_valid | output | 1 | Fault record holds an access |
| fs_addr | output | 32 | Recorded faulting address |
| fs_kind | output | 2 | Recorded access kind |
| fs_priv | output | 1 | Recorded privilege |

## Verification
The access path has no registers. A corrupted region word, size mask or priority choice therefore shows up on acc_region, the attributes or acc_fault for the very next access that touches the affected address. Accesses are aimed near each region's base and across overlaps, so such errors surface within a few accesses. A wrong fault-record state shows up on the clock after a fault or a clear: fs_valid is wrong, or a later fault replaces the recorded address. The write-then-access ordering checks that a new configuration is not used in the cycle in which it is written.

// File: rtl/prot_region_pkg.sv
package prot_region_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned N_REG   = 8;
    localparam int unsigned IDX_W   = $clog2(N_REG);
    localparam int unsigned CFG_AW  = 5;
    localparam int unsigned SZ_W    = 5;
    localparam int unsigned SZ_MIN  = 4;
    localparam int unsigned BASE_LO = SZ_MIN + 1;

    localparam logic [CFG_AW-1:0] CFG_GLOBAL = CFG_AW'(2 * N_REG);
    localparam logic [CFG_AW-1:0] CFG_FSCLR  = CFG_AW'(2 * N_REG + 1);

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic [2:0] tex;
        logic       cach;
        logic       buff;
        logic       shr;
        logic       xn;
    } mem_attr_t;

    typedef struct packed {
        logic              en;
        logic [SZ_W-1:0]   szc;
        logic [2:0]        ap;
        mem_attr_t         attr;
        logic [ADDR_W-1:0] base;
    } region_t;

endpackage

// File: rtl/prot_region_regs.sv
module prot_region_regs
    import prot_region_pkg::*;
#(
    parameter int unsigned N = N_REG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [DATA_W-1:0]   cfg_wdata,
    output region_t [N-1:0]     regions,
    output logic                glb_en,
    output logic                fs_clr
);

    for (genvar g = 0; g < N; g++) begin : g_slot
        region_t r_q;
        logic    hit_base;
        logic    hit_ctl;

        assign hit_base = cfg_we && (cfg_addr == CFG_AW'(2 * g));
        assign hit_ctl  = cfg_we && (cfg_addr == CFG_AW'(2 * g + 1));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                if (hit_base) begin
                    r_q.base <= {cfg_wdata[ADDR_W-1:BASE_LO], {BASE_LO{1'b0}}};
                end
                if (hit_ctl) begin
                    r_q.en        <= cfg_wdata[0];
                    r_q.szc       <= cfg_wdata[5:1];
                    r_q.ap        <= cfg_wdata[10:8];
                    r_q.attr.xn   <= cfg_wdata[12];
                    r_q.attr.tex  <= cfg_wdata[18:16];
                    r_q.attr.shr  <= cfg_wdata[19];
                    r_q.attr.cach <= cfg_wdata[20];
                    r_q.attr.buff <= cfg_wdata[21];
                end
            end
        end

        assign regions[g] = r_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            glb_en <= 1'b0;
        end else if (cfg_we && (cfg_addr == CFG_GLOBAL)) begin
            glb_en <= cfg_wdata[0];
        end
    end

    assign fs_clr = cfg_we && (cfg_addr == CFG_FSCLR);

    logic unused_bits;
    assign unused_bits = ^{cfg_wdata[DATA_W-1:22], cfg_wdata[15:13], cfg_wdata[11], cfg_wdata[7:6]};

endmodule

// File: rtl/prot_region_match.sv
module prot_region_match
    import prot_region_pkg::*;
#(
    parameter int unsigned N = N_REG
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  region_t [N-1:0]       regions,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  hit,
    output logic [$clog2(N)-1:0]  idx
);

    localparam int unsigned IW = $clog2(N);

    logic [N-1:0] hits;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        logic [ADDR_W-1:0] keep;

        always_comb begin
            for (int b = 0; b < ADDR_W; b++) begin
                keep[b] = (b > int'(regions[g].szc));
            end
        end

        assign hits[g] = regions[g].en
                      && (regions[g].szc >= SZ_W'(SZ_MIN))
                      && (((addr ^ regions[g].base) & keep) == '0);
    end

    always_comb begin
        hit = |hits;
        idx = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (hits[i]) idx = IW'(i);
        end
    end

    AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((hits >> idx) == N'(1)));  // R3

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (idx == '0));  // R4

endmodule

// File: rtl/prot_region_perm.sv
module prot_region_perm
    import prot_region_pkg::*;
#(
    parameter int unsigned N = N_REG
) (
    input  region_t [N-1:0]       regions,
    input  logic                  hit,
    input  logic [$clog2(N)-1:0]  idx,
    input  logic                  glb_en,
    input  logic                  valid,
    input  logic                  priv,
    input  acc_kind_e             kind,
    output logic                  fault,
    output mem_attr_t             attr
);

    region_t sel;
    logic    rd_ok;
    logic    wr_ok;
    logic    deny;
    logic    so_type;

    assign sel = regions[idx];

    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        unique case (sel.ap)
            3'd1: begin rd_ok = priv; wr_ok = priv; end
            3'd2: begin rd_ok = 1'b1; wr_ok = priv; end
            3'd3: begin rd_ok = 1'b1; wr_ok = 1'b1; end
            3'd5: begin rd_ok = priv; end
            3'd6: begin rd_ok = 1'b1; end
            default: begin rd_ok = 1'b0; wr_ok = 1'b0; end
        endcase
    end

    always_comb begin
        if (!glb_en) begin
            deny = 1'b0;
        end else if (!hit) begin
            deny = !priv;
        end else begin
            unique case (kind)
                ACC_WRITE: deny = !wr_ok;
                ACC_FETCH: deny = !rd_ok || sel.attr.xn;
                default:   deny = !rd_ok;
            endcase
        end
    end

    assign fault   = valid && deny;
    assign so_type = (sel.attr.tex == 3'd0) && !sel.attr.cach && !sel.attr.buff;

    always_comb begin
        attr = '0;
        if (glb_en && hit) begin
            attr     = sel.attr;
            attr.shr = sel.attr.shr || so_type;
        end
    end

endmodule

// File: rtl/prot_fault_hold.sv
module prot_fault_hold
    import prot_region_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault,
    input  logic              clr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        kind,
    input  logic              priv,
    output logic              fs_valid,
    output logic [ADDR_W-1:0] fs_addr,
    output logic [1:0]        fs_kind,
    output logic              fs_priv
);

    typedef enum logic {
        FS_EMPTY = 1'b0,
        FS_HELD  = 1'b1
    } fs_state_e;

    fs_state_e st_q;
    fs_state_e st_d;
    logic      load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= FS_EMPTY;
            fs_addr <= '0;
            fs_kind <= '0;
            fs_priv <= 1'b0;
        end else begin
            st_q <= st_d;
            if (load) begin
                fs_addr <= addr;
                fs_kind <= kind;
                fs_priv <= priv;
            end
        end
    end

    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            FS_EMPTY: begin
                if (fault) begin
                    load = 1'b1;
                    st_d = FS_HELD;
                end
            end
            FS_HELD: begin
                if (clr) begin
                    if (fault) load = 1'b1;
                    else       st_d = FS_EMPTY;
                end
            end
            default: st_d = FS_EMPTY;
        endcase
    end

    assign fs_valid = (st_q == FS_HELD);

    AST_FS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_valid && !clr) |=> (fs_valid && $stable(fs_addr) && $stable(fs_kind) && $stable(fs_priv)));  // R10

    AST_FS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fs_valid && fault) |=> (fs_valid && (fs_addr == $past(addr))));  // R10

    AST_FS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_valid && clr && !fault) |=> !fs_valid);  // R10

endmodule

// File: rtl/prot_region_chk.sv
module prot_region_chk
    import prot_region_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    input  logic               acc_valid,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_priv,
    input  logic [1:0]         acc_kind,
    output logic               acc_fault,
    output logic               acc_hit,
    output logic [IDX_W-1:0]   acc_region,
    output logic [2:0]         attr_tex,
    output logic               attr_cach,
    output logic               attr_buff,
    output logic               attr_shr,
    output logic               attr_xn,
    output logic               fs_valid,
    output logic [ADDR_W-1:0]  fs_addr,
    output logic [1:0]         fs_kind,
    output logic               fs_priv
);

    region_t [N_REG-1:0] regions;
    logic                glb_en;
    logic                fs_clr;
    logic                m_hit;
    logic [IDX_W-1:0]    m_idx;
    mem_attr_t           attr;

    prot_region_regs #(.N(N_REG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .regions   (regions),
        .glb_en    (glb_en),
        .fs_clr    (fs_clr)
    );

    prot_region_match #(.N(N_REG)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .regions (regions),
        .addr    (acc_addr),
        .hit     (m_hit),
        .idx     (m_idx)
    );

    prot_region_perm #(.N(N_REG)) u_perm (
        .regions (regions),
        .hit     (m_hit),
        .idx     (m_idx),
        .glb_en  (glb_en),
        .valid   (acc_valid),
        .priv    (acc_priv),
        .kind    (acc_kind_e'(acc_kind)),
        .fault   (acc_fault),
        .attr    (attr)
    );

    prot_fault_hold u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (acc_fault),
        .clr      (fs_clr),
        .addr     (acc_addr),
        .kind     (acc_kind),
        .priv     (acc_priv),
        .fs_valid (fs_valid),
        .fs_addr  (fs_addr),
        .fs_kind  (fs_kind),
        .fs_priv  (fs_priv)
    );

    assign acc_hit    = glb_en && m_hit;
    assign acc_region = acc_hit ? m_idx : '0;
    assign attr_tex   = attr.tex;
    assign attr_cach  = attr.cach;
    assign attr_buff  = attr.buff;
    assign attr_shr   = attr.shr;
    assign attr_xn    = attr.xn;

    AST_BG_UNPRIV_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && acc_valid && !acc_hit && !acc_priv) |-> acc_fault);  // R4

    AST_BG_PRIV_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_en && !acc_hit && acc_priv) |-> !acc_fault);  // R4

    AST_OFF_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (!acc_fault && !acc_hit && (acc_region == '0)));  // R9

    AST_XN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && attr_xn && (acc_kind == 2'd0)) |-> acc_fault);  // R6

    AST_SO_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && (attr_tex == 3'd0) && !attr_cach && !attr_buff) |-> attr_shr);  // R8

    AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> !acc_fault);  // R11

endmodule

// File: tb/prot_region_chk_test.sv
`timescale 1ns/1ps
module prot_region_chk_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_priv = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        acc_fault, acc_hit, attr_cach, attr_buff, attr_shr, attr_xn;
    logic [2:0]  acc_region, attr_tex;
    logic        fs_valid, fs_priv;
    logic [31:0] fs_addr;
    logic [1:0]  fs_kind;

    always #2.5 clk = ~clk;

    prot_region_chk uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_kind(acc_kind),
        .acc_fault(acc_fault), .acc_hit(acc_hit), .acc_region(acc_region),
        .attr_tex(attr_tex), .attr_cach(attr_cach), .attr_buff(attr_buff),
        .attr_shr(attr_shr), .attr_xn(attr_xn),
        .fs_valid(fs_valid), .fs_addr(fs_addr), .fs_kind(fs_kind), .fs_priv(fs_priv)
    );

    // reference state kept from the requirements
    logic [31:0] m_base [8];
    logic        m_en [8];
    logic [4:0]  m_sz [8];
    logic [2:0]  m_ap [8];
    logic        m_xn [8];
    logic [2:0]  m_tex [8];
    logic        m_s [8];
    logic        m_c [8];
    logic        m_b [8];
    logic        m_glb;
    logic        m_fsv;
    logic [31:0] m_fsa;
    logic [1:0]  m_fsk;
    logic        m_fsp;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 0;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_eval(output logic f, output logic h, output logic [2:0] r,
                              output logic [2:0] tex, output logic c, output logic b,
                              output logic s, output logic xn);
        logic rd, wr;
        f = 0; h = 0; r = 0; tex = 0; c = 0; b = 0; s = 0; xn = 0;
        if (m_glb) begin
            for (int i = 7; i >= 0; i--) begin
                if (!h && m_en[i] && m_sz[i] >= 5'd4 &&
                    ((({32'd0, acc_addr} ^ {32'd0, m_base[i]}) >> (m_sz[i] + 6'd1)) == 64'd0)) begin
                    h = 1; r = 3'(i);
                end
            end
            if (!h) begin
                f = !acc_priv;
            end else begin
                case (m_ap[r])
                    3'd0: begin rd = 0; wr = 0; end
                    3'd1: begin rd = acc_priv; wr = acc_priv; end
                    3'd2: begin rd = 1; wr = acc_priv; end
                    3'd3: begin rd = 1; wr = 1; end
                    3'd5: begin rd = acc_priv; wr = 0; end
                    3'd6: begin rd = 1; wr = 0; end
                    default: begin rd = 0; wr = 0; end
                endcase
                if (acc_kind == 2'd2) f = !wr;
                else if (acc_kind == 2'd0) f = !rd || m_xn[r];
                else f = !rd;
                tex = m_tex[r]; c = m_c[r]; b = m_b[r]; xn = m_xn[r];
                s = m_s[r] || (m_tex[r] == 3'd0 && !m_c[r] && !m_b[r]);
            end
        end
        f = f && acc_valid;
    endtask

    task automatic step(input string tag);
        logic ef, eh, ec, eb, es, ex;
        logic [2:0] er, et;
        #1;
        model_eval(ef, eh, er, et, ec, eb, es, ex);
        check(tag, "fault", {31'd0, acc_fault}, {31'd0, ef});
        check(tag, "hit", {31'd0, acc_hit}, {31'd0, eh});
        check(tag, "region", {29'd0, acc_region}, {29'd0, er});
        check(tag, "attr", {26'd0, attr_tex, attr_cach, attr_buff, attr_shr, attr_xn},
                           {26'd0, et, ec, eb, es, ex});
        check(tag, "fs_valid", {31'd0, fs_valid}, {31'd0, m_fsv});
        if (m_fsv) begin
            check(tag, "fs_addr", fs_addr, m_fsa);
            check(tag, "fs_info", {29'd0, fs_kind, fs_priv}, {29'd0, m_fsk, m_fsp});
        end
        @(posedge clk);
        if (!m_fsv) begin
            if (ef) begin m_fsv = 1; m_fsa = acc_addr; m_fsk = acc_kind; m_fsp = acc_priv; end
        end else if (cfg_we && cfg_addr == 5'd17) begin
            if (ef) begin m_fsa = acc_addr; m_fsk = acc_kind; m_fsp = acc_priv; end
            else m_fsv = 0;
        end
        if (cfg_we) begin
            if (cfg_addr == 5'd16) m_glb = cfg_wdata[0];
            else if (cfg_addr < 5'd16) begin
                if (!cfg_addr[0]) m_base[cfg_addr[3:1]] = {cfg_wdata[31:5], 5'd0};
                else begin
                    m_en[cfg_addr[3:1]]  = cfg_wdata[0];
                    m_sz[cfg_addr[3:1]]  = cfg_wdata[5:1];
                    m_ap[cfg_addr[3:1]]  = cfg_wdata[10:8];
                    m_xn[cfg_addr[3:1]]  = cfg_wdata[12];
                    m_tex[cfg_addr[3:1]] = cfg_wdata[18:16];
                    m_s[cfg_addr[3:1]]   = cfg_wdata[19];
                    m_c[cfg_addr[3:1]]   = cfg_wdata[20];
                    m_b[cfg_addr[3:1]]   = cfg_wdata[21];
                end
            end
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d; acc_valid = 0;
        step(tag);
        cfg_we = 0;
    endtask

    function automatic logic [31:0] ctl(input logic en, input logic [4:0] sz, input logic [2:0] ap,
                                        input logic xn, input logic [2:0] tex, input logic s,
                                        input logic c, input logic b);
        return {10'd0, b, c, s, tex, 3'd0, xn, 1'b0, ap, 2'd0, sz, en};
    endfunction

    task automatic acc(input logic [31:0] a, input logic p, input logic [1:0] k, input string tag);
        acc_valid = 1; acc_addr = a; acc_priv = p; acc_kind = k;
        step(tag);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_base[i] = 0; m_en[i] = 0; m_sz[i] = 0; m_ap[i] = 0; m_xn[i] = 0;
            m_tex[i] = 0; m_s[i] = 0; m_c[i] = 0; m_b[i] = 0;
        end
        m_glb = 0; m_fsv = 0; m_fsa = 0; m_fsk = 0; m_fsp = 0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state, checking off, unprivileged access granted
        acc(32'h1234_5678, 0, 2'd2, "R9");
        // R1: configuration, region 0 and overlapping region 1
        wr(5'd0, 32'h2000_0000, "R1");
        wr(5'd1, ctl(1, 5'd15, 3'd3, 0, 3'd1, 0, 1, 1), "R1");
        wr(5'd2, 32'h2000_1000, "R1");
        wr(5'd3, ctl(1, 5'd11, 3'd6, 0, 3'd0, 1, 1, 0), "R1");
        acc(32'h2000_1004, 0, 2'd2, "R9");           // still off: granted
        wr(5'd16, 32'd1, "R1");
        // R3: overlap, region 1 wins and is read-only
        acc(32'h2000_1004, 0, 2'd2, "R3");
        acc(32'h2000_1ffc, 0, 2'd1, "R3");
        acc(32'h2000_2000, 0, 2'd2, "R3");
        // R4: background
        acc(32'h6000_0000, 1, 2'd2, "R4");
        acc(32'h6000_0000, 0, 2'd1, "R4");
        // R6 / R7: execute-never and shared table
        wr(5'd4, 32'h0800_0000, "R6");
        wr(5'd5, ctl(1, 5'd9, 3'd3, 1, 3'd0, 0, 1, 0), "R6");
        acc(32'h0800_0010, 1, 2'd0, "R6");
        acc(32'h0800_0010, 0, 2'd1, "R6");
        wr(5'd5, ctl(1, 5'd9, 3'd1, 0, 3'd0, 0, 1, 0), "R7");
        acc(32'h0800_0010, 0, 2'd0, "R7");
        acc(32'h0800_0010, 1, 2'd0, "R7");
        acc(32'h0800_0010, 1, 2'd3, "R7");
        // R8: strongly ordered forced shared
        wr(5'd7, ctl(1, 5'd4, 3'd3, 0, 3'd0, 0, 0, 0), "R8");
        wr(5'd6, 32'h4000_0000, "R8");
        acc(32'h4000_0004, 0, 2'd1, "R8");
        // R2: small size code never matches, low base bits ignored
        wr(5'd8, 32'h5000_0000, "R2");
        wr(5'd9, ctl(1, 5'd3, 3'd3, 0, 3'd1, 0, 0, 0), "R2");
        acc(32'h5000_0004, 0, 2'd1, "R2");
        wr(5'd8, 32'h5000_0f60, "R2");
        wr(5'd9, ctl(1, 5'd11, 3'd3, 0, 3'd1, 0, 0, 0), "R2");
        acc(32'h5000_0004, 0, 2'd1, "R2");
        acc(32'h5000_1000, 0, 2'd1, "R2");
        // R5: reserved permission codes
        wr(5'd9, ctl(1, 5'd11, 3'd4, 0, 3'd1, 0, 0, 0), "R5");
        acc(32'h5000_0004, 1, 2'd1, "R5");
        wr(5'd9, ctl(1, 5'd11, 3'd7, 0, 3'd1, 0, 0, 0), "R5");
        acc(32'h5000_0004, 1, 2'd1, "R5");
        // R1: write and access in the same cycle uses the old setting
        cfg_we = 1; cfg_addr = 5'd9; cfg_wdata = ctl(1, 5'd11, 3'd3, 0, 3'd1, 0, 0, 0);
        acc(32'h5000_0008, 1, 2'd1, "R1");
        cfg_we = 0;
        acc(32'h5000_0008, 1, 2'd1, "R1");
        // R10: fault record
        wr(5'd17, 32'd0, "R10");
        acc(32'h7000_0040, 0, 2'd2, "R10");
        acc(32'h7000_0080, 0, 2'd0, "R10");
        acc(32'h7000_0080, 1, 2'd1, "R10");
        cfg_we = 1; cfg_addr = 5'd17; cfg_wdata = 0;
        acc(32'h7100_0000, 0, 2'd1, "R10");
        cfg_we = 0;
        acc(32'h7100_0000, 1, 2'd1, "R10");
        wr(5'd17, 32'd0, "R10");
        acc(32'h7100_0000, 1, 2'd1, "R10");
        // R11: no valid, no fault
        acc_valid = 0; acc_addr = 32'h7000_0000; acc_priv = 0;
        step("R11");
        // random mix
        for (int n = 0; n < 400; n++) begin
            int pick;
            pick = int'($urandom_range(0, 9));
            if (pick == 0) begin
                int ri;
                ri = int'($urandom_range(0, 7));
                wr(5'(2 * ri), $urandom & 32'hFFFF_F000, "RND");
            end else if (pick == 1) begin
                int ri;
                ri = int'($urandom_range(0, 7));
                wr(5'(2 * ri + 1), ctl(1'($urandom_range(0, 3) != 0), 5'($urandom_range(2, 20)),
                    3'($urandom), 1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom)), "RND");
            end else if (pick == 2 && n % 7 == 0) begin
                wr(5'd17, 32'd0, "RND");
            end else begin
                int ri;
                logic [31:0] a;
                ri = int'($urandom_range(0, 7));
                a = m_base[ri] + ($urandom & 32'h0000_3FFF);
                if ($urandom_range(0, 7) == 0) a = $urandom;
                cfg_we = 0;
                acc(a, 1'($urandom), 2'($urandom), "RND");
            end
        end
        // R9: global disable again
        wr(5'd16, 32'd0, "R9");
        acc(32'h2000_1004, 0, 2'd2, "R9");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule